// File: doc/BRIEF.md
# Buffered Output-Compare PWM Timer

This block is a 16-bit up-counter driven by a power-of-two prescaler of the bus clock. The counter wraps at a programmable modulo value. Two output-compare channels sit beside it. Each channel can toggle its pin when the counter wraps and force the pin to a chosen level when the counter reaches its compare value. Together these two actions produce a PWM waveform. The period comes from the modulo value and the pulse width from the compare value.

When the two channels are linked, they act as one buffered channel on pin 0. The two compare registers take turns. One drives the match logic, and the other holds the next duty value. At each wrap, the register that software wrote most recently becomes the active one, so a new duty value never cuts a pulse short. A status output names the active register, so software can write to the other one. Pin 1 is handed back for other use while the channels are linked.

Software programs the block over a one-cycle write strobe with a 2-bit address. Address 0 holds the modulo value, address 1 the control bits, address 2 compare register 0 and address 3 compare register 1.

Top module: `bpwm_timer`

## Requirements
- R1: While reset is held, the outputs read as follows: count is 0, pwm0 and pwm1 are 0, active_ch is 0 and pwm1_oe is 1. The modulo value resets to 0xFFFF.
- R2: The prescaler select N is held in control bits [2:0]. The counter advances once every 2^N bus clocks for N from 0 to 6, and N=7 behaves as N=6.
- R3: On each advance the counter goes to 0 if it is at or above the modulo value, and otherwise increments by 1. The period is therefore (modulo+1)·2^N bus clocks, and a modulo of 0 keeps the counter at 0.
- R4: The toggle-on-wrap bits are control bit 4 for pin 0 and bit 6 for pin 1. When a channel's bit is set, its pin inverts on every wrap. When the bit is clear, the wrap leaves the pin alone.
- R5: A compare match happens on the advance that brings the counter to the active compare value. The polarity bits are control bit 5 for pin 0 and bit 7 for pin 1. Polarity 0 drives the pin to 0 on a match and polarity 1 drives it to 1. A match on the same advance as a wrap overrides the toggle, so a compare value of 0 with polarity 0 keeps the pin at 0.
- R6: A compare value above the modulo value never matches, so with toggling enabled the pin inverts on each wrap and gives a 50% square wave of twice the period.
- R7: Setting link bit 3 makes compare register 0 active, whichever register was written before, and active_ch reads 0. While linked, pwm1_oe is 0 and pwm1 holds its value.
- R8: While linked, a write to the inactive compare register leaves the active one unchanged until the next wrap. At that wrap active_ch switches to the written register.
- R9: While linked, each wrap makes active the compare register that was written most recently. If both are written within one period, the later write decides.
- R10: A write to the compare register that is currently active is used by the match logic at once, within the current period.
- R11: While unlinked, pin 1 runs as an independent channel using compare register 1, toggle bit 6 and polarity bit 7, with pwm1_oe at 1. Pin 0 uses compare register 0.
- R12: The write address map sets the behaviour: 0 for modulo, 1 for control, 2 for compare 0 and 3 for compare 1. A write takes effect at the clock edge that samples wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| pwm0 | output | 1 | Channel 0 pin, carries the buffered channel when linked |
| pwm1 | output | 1 | Channel 1 pin |
| pwm1_oe | output | 1 | High while pin 1 is driven by the timer |
| active_ch | output | 1 | Compare register currently used by the buffered channel |

## Verification
The assertions rely on writes arriving as single-cycle strobes that software places away from the wrap cycle. They also rely on the prescaler select staying fixed inside a measured interval. A compare write on the very advance that causes a wrap only counts toward the following wrap.

The stimulus respects both assumptions. It changes the configuration only between measurements, and it issues every buffered write on the cycle right after a wrap, while the counter is at 0 or 1 and far from the modulo value. It also clears the link bit before each new configuration, so every linked test starts from a fresh link event.

// File: rtl/bpwm_timer.sv
module bpwm_timer #(
  parameter int CW   = 16,
  parameter int PMAX = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count,
  output logic          pwm0,
  output logic          pwm1,
  output logic          pwm1_oe,
  output logic          active_ch
);
  localparam int SW = $clog2(PMAX + 1);

  logic [CW-1:0]   modulo, cmp0, cmp1, cnt, cnt_nx, act_cmp;
  logic [PMAX-1:0] pre, mask;
  logic [2:0]      psel;
  logic [SW-1:0]   psel_eff;
  logic            link, tov0, pol0, tov1, pol1;
  logic            act, last, pwm0_q, pwm1_q;
  logic            tick, ovf, m0, m1;
  logic            wr_ctl, wr_c0, wr_c1, link_set;

  assign wr_ctl   = wr_en && wr_addr == 2'd1;
  assign wr_c0    = wr_en && wr_addr == 2'd2;
  assign wr_c1    = wr_en && wr_addr == 2'd3;
  assign link_set = wr_ctl && wr_data[3] && !link;

  assign psel_eff = (int'(psel) > PMAX) ? SW'(PMAX) : SW'(psel);
  assign mask     = ~({PMAX{1'b1}} << psel_eff);
  assign tick     = (pre & mask) == mask;
  assign ovf      = tick && cnt >= modulo;
  assign cnt_nx   = ovf ? '0 : cnt + 1'b1;
  assign act_cmp  = (link && act) ? cmp1 : cmp0;
  assign m0       = tick && cnt_nx == act_cmp;
  assign m1       = tick && !link && cnt_nx == cmp1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modulo <= '1;
      cmp0   <= '0;
      cmp1   <= '0;
      psel   <= '0;
      link   <= 1'b0;
      tov0   <= 1'b0;
      pol0   <= 1'b0;
      tov1   <= 1'b0;
      pol1   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: modulo <= wr_data;
        2'd1: {pol1, tov1, pol0, tov0, link, psel} <= wr_data[7:0];
        2'd2: cmp0 <= wr_data;
        default: cmp1 <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (tick) cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      last <= 1'b0;
    end else if (link_set) begin
      act  <= 1'b0;
      last <= 1'b0;
    end else begin
      if (wr_c0) last <= 1'b0;
      else if (wr_c1) last <= 1'b1;
      if (link && ovf) act <= last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm0_q <= 1'b0;
      pwm1_q <= 1'b0;
    end else begin
      if (m0) pwm0_q <= pol0;
      else if (ovf && tov0) pwm0_q <= ~pwm0_q;
      if (!link) begin
        if (m1) pwm1_q <= pol1;
        else if (ovf && tov1) pwm1_q <= ~pwm1_q;
      end
    end
  end

  assign count     = cnt;
  assign pwm0      = pwm0_q;
  assign pwm1      = pwm1_q;
  assign pwm1_oe   = !link;
  assign active_ch = act;
endmodule

// File: rtl/bpwm_timer_chk.sv
module bpwm_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ovf,
  input logic          m0,
  input logic          link,
  input logic          link_set,
  input logic          act,
  input logic [CW-1:0] cnt,
  input logic          pwm0_q,
  input logic          pwm1_q
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf) |=> cnt == CW'($past(cnt) + 1'b1));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt == '0);

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !m0) |=> $stable(pwm0_q));

  assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link |=> $stable(pwm1_q));

  assert_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_set |=> !act);

  assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !link_set) |=> $stable(act));
endmodule

bind bpwm_timer bpwm_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ovf(ovf), .m0(m0), .link(link),
  .link_set(link_set), .act(act), .cnt(cnt), .pwm0_q(pwm0_q), .pwm1_q(pwm1_q)
);

// File: tb/bpwm_timer_bench.sv
module bpwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        pwm0, pwm1, pwm1_oe, active_ch;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bpwm_timer u_bpwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .pwm0(pwm0), .pwm1(pwm1),
    .pwm1_oe(pwm1_oe), .active_ch(active_ch)
  );

  localparam logic [15:0] LINK = 16'h08, TOV0 = 16'h10, POL0 = 16'h20,
                          TOV1 = 16'h40, POL1 = 16'h80;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic pin(input int w);
    return (w == 1) ? pwm1 : pwm0;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R12 map: 0 modulo, 1 control, 2 compare 0, 3 compare 1
  task automatic cfg(input int md, input int c0, input int c1, input logic [15:0] ctl);
    wr(2'd1, ctl & ~LINK);
    wr(2'd0, 16'(md));
    wr(2'd2, 16'(c0));
    wr(2'd3, 16'(c1));
    wr(2'd1, ctl);
  endtask

  task automatic sync(input int w, input logic lvl);
    while (pin(w) == lvl) @(negedge clk);
    while (pin(w) != lvl) @(negedge clk);
  endtask

  task automatic span(input int w, input logic lvl, output int a, output int b);
    a = 0; b = 0;
    while (pin(w) == lvl) begin a++; @(negedge clk); end
    while (pin(w) != lvl) begin b++; @(negedge clk); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 pwm0", int'(pwm0), 0);
    chk("R1 pwm1", int'(pwm1), 0);
    chk("R1 active", int'(active_ch), 0);
    chk("R1 oe", int'(pwm1_oe), 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_count();
    int errs = 0, mx = 0, prev;
    cfg(9, 0, 0, 16'h0);
    prev = int'(count);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (int'(count) != ((prev >= 9) ? 0 : prev + 1)) errs++;
      if (int'(count) > mx) mx = int'(count);
      prev = int'(count);
    end
    chk("R3 sequence errors", errs, 0);
    chk("R3 max count", mx, 9);
  endtask

  task automatic t_mod0();
    int a, b, nz = 0;
    cfg(0, 5, 0, LINK | TOV0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (count != 0) nz++;
    end
    chk("R3 modulo0 count", nz, 0);
    sync(0, 1'b1); span(0, 1'b1, a, b);
    chk("R3 modulo0 high", a, 1);
    chk("R3 modulo0 low", b, 1);
  endtask

  task automatic t_pwm(input int md, input int c, input logic [15:0] ps,
                       input int eh, input int el, input string req);
    int a, b;
    cfg(md, c, 0, LINK | TOV0 | ps);
    sync(0, 1'b1); span(0, 1'b1, a, b);
    chk({req, " high"}, a, eh);
    chk({req, " low"}, b, el);
  endtask

  task automatic t_pol1();
    int a, b;
    cfg(15, 5, 0, LINK | TOV0 | POL0);
    sync(0, 1'b0); span(0, 1'b0, a, b);
    chk("R5 pol1 low", a, 5);
    chk("R5 pol1 high", b, 11);
  endtask

  task automatic t_notov();
    int ch = 0;
    logic p;
    cfg(7, 2, 0, LINK | POL0);
    repeat (20) @(negedge clk);
    chk("R4 no-toggle level", int'(pwm0), 1);
    p = pwm0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (pwm0 != p) ch++;
      p = pwm0;
    end
    chk("R4 no-toggle changes", ch, 0);
  endtask

  task automatic t_zero();
    int ones = 0;
    cfg(7, 0, 0, LINK | TOV0);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (pwm0) ones++;
    end
    chk("R5 zero duty high cycles", ones, 0);
  endtask

  task automatic t_buffer();
    int a, b;
    logic p1;
    cfg(19, 4, 15, LINK | TOV0 | TOV1);
    chk("R7 oe while linked", int'(pwm1_oe), 0);
    chk("R7 active after link", int'(active_ch), 0);
    p1 = pwm1;
    sync(0, 1'b1); span(0, 1'b1, a, b);
    chk("R7 first source high", a, 4);
    chk("R7 pwm1 parked", int'(pwm1), int'(p1));
    wr(2'd3, 16'd10);
    chk("R8 active before wrap", int'(active_ch), 0);
    span(0, 1'b1, a, b);
    chk("R8 current pulse kept", a, 3);
    chk("R8 current low", b, 16);
    chk("R8 active after wrap", int'(active_ch), 1);
    wr(2'd2, 16'd6);
    span(0, 1'b1, a, b);
    chk("R9 ch1 pulse", a, 9);
    chk("R9 back to ch0", int'(active_ch), 0);
    span(0, 1'b1, a, b);
    chk("R9 ch0 pulse", a, 6);
    wr(2'd2, 16'd12);
    chk("R10 active stays", int'(active_ch), 0);
    span(0, 1'b1, a, b);
    chk("R10 immediate high", a, 11);
    chk("R10 immediate low", b, 8);
    wr(2'd3, 16'd3);
    wr(2'd2, 16'd7);
    span(0, 1'b1, a, b);
    chk("R9 later write wins now", a, 5);
    chk("R9 later write active", int'(active_ch), 0);
    span(0, 1'b1, a, b);
    chk("R9 later write pulse", a, 7);
  endtask

  task automatic t_unlinked();
    int a, b;
    cfg(19, 4, 9, TOV0 | TOV1);
    chk("R11 oe", int'(pwm1_oe), 1);
    sync(1, 1'b1); span(1, 1'b1, a, b);
    chk("R11 pwm1 high", a, 9);
    chk("R11 pwm1 low", b, 11);
    sync(0, 1'b1); span(0, 1'b1, a, b);
    chk("R12 pwm0 uses compare 0", a, 4);
  endtask

  initial begin
    t_reset();
    t_count();
    t_mod0();
    t_pwm(255, 128, 16'h0, 128, 128, "R5 half duty");
    t_pwm(9, 3, 16'h2, 12, 28, "R2 div4");
    t_pwm(3, 1, 16'h7, 64, 192, "R2 select7");
    t_pwm(9, 50, 16'h0, 10, 10, "R6 no match");
    t_pol1();
    t_notov();
    t_zero();
    t_buffer();
    t_unlinked();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule